// File: doc/BRIEF.md
# Electronic Shutter Exposure Controller

This block sits next to the readout sequencer of an interline image sensor and decides how long each exposure lasts. It issues two timing requests. The transfer request moves charge from the photodiodes into the vertical register, and its falling edge ends integration. The substrate-clear pulse empties the photodiodes, and its falling edge starts integration. Integration time is the interval between those two falling edges.

When the programmed exposure is shorter than one nominal frame and the shutter is enabled, the substrate pulse is placed so that its falling edge comes exactly N line markers before the next transfer falling edge, where N is the exposure in lines. Exposures of one frame or more never use the substrate pulse. Instead, the block reports a longer line count for the frame, so the sequencer keeps clocking dummy lines. Only the first nominal-frame worth of lines is flagged as image data. For example, doubling the exposure of a 1092-line frame reads 2184 lines and marks only the first 1092 as valid. At the nominal horizontal rate, a frame is roughly 111 ms, which gives about 9 frames per second.

The sequencer supplies a one-cycle line marker at the start of every line and a frame marker together with the line marker of line 0. Settings are captured only on the frame marker. The sequencer must keep every line longer than `PULSE_END` cycles.

Top module: `exposure_ctl`

## Requirements
- R1: After reset, `xfer_req`, `sub_pulse` and `img_valid` are 0 and `frame_lines` equals `IMG_LINES`.
- R2: For each frame, `xfer_req` goes high after the (`PULSE_END`-`XFER_CYC`)-th rising clock edge following the edge that samples `frame_tick`, and it goes low after the `PULSE_END`-th such edge. It is high for exactly `XFER_CYC` cycles.
- R3: When the shutter is enabled and the clamped exposure N is below `IMG_LINES`, one `sub_pulse` is issued in line index `IMG_LINES`-N. It falls after the `PULSE_END`-th edge following that line's marker, so its falling edge comes exactly N lines before the next frame's transfer falling edge.
- R4: An exposure of 0 lines is treated as 1. The substrate pulse width is `sub_width` cycles, with 0 treated as 1 and any value above `PULSE_END` treated as `PULSE_END`.
- R5: When the shutter is disabled, or the clamped exposure is at least `IMG_LINES`, no `sub_pulse` is issued in that frame.
- R6: `frame_lines` equals the larger of the clamped exposure and `IMG_LINES`, so long exposures are made by padding the frame with dummy lines.
- R7: Once a frame marker has been seen, `img_valid` is high during line indices 0 to `IMG_LINES`-1 and low on padding lines.
- R8: `exp_lines`, `shutter_en` and `sub_width` are sampled only on the clock edge that samples `frame_tick`. Changes at any other time have no effect until the next frame marker.
- R9: `sub_pulse` and `xfer_req` are never high in the same cycle.
- R10: Before the first frame marker, no pulse is issued and `img_valid` stays 0, even when line markers arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle frame start marker, given together with the line 0 marker |
| line_tick | input | 1 | One-cycle line start marker |
| exp_lines | input | LINE_W | Exposure length in lines |
| shutter_en | input | 1 | Allows the substrate pulse for short exposures |
| sub_width | input | $clog2(PULSE_END+1) | Substrate pulse width in cycles |
| xfer_req | output | 1 | Photodiode-to-register transfer request; its falling edge ends integration |
| sub_pulse | output | 1 | Substrate-clear pulse; its falling edge starts integration |
| frame_lines | output | LINE_W | Number of lines the sequencer must clock in the current frame |
| img_valid | output | 1 | The current line carries image data |

## Verification
Two events can fall in the same cycle: the frame marker that latches new settings, and a change of those settings on the cycle just after it. The bench presents each frame's settings on the frame-marker cycle and replaces them with unrelated values one cycle later. Pulse placement, pulse width and `frame_lines` must then follow only the values that were present at the marker. A scoreboard holds the expected rising and falling cycles of both pulses and compares each observed edge against them. For every short exposure, it also measures the gap from the substrate falling edge to the next transfer falling edge and expects exactly N line periods.

// File: rtl/exp_ctl_pkg.sv
package exp_ctl_pkg;

  // Exposure of zero lines is promoted to one line.
  function automatic int unsigned clamp_lines(int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

  // Lines to clock in a frame: pad up to the exposure when it is longer.
  function automatic int unsigned frame_len(int unsigned n, int unsigned img);
    return (n > img) ? n : img;
  endfunction

  // The substrate pulse is used only for exposures shorter than a frame.
  function automatic bit shutter_used(bit en, int unsigned n, int unsigned img);
    return en && (n < img);
  endfunction

  // Line index whose marker starts the integration window.
  function automatic int unsigned sub_line(int unsigned n, int unsigned img);
    return (n < img) ? (img - n) : 0;
  endfunction

  // Pulse width forced into the range 1..pe.
  function automatic int unsigned clamp_width(int unsigned w, int unsigned pe);
    if (w == 0) return 1;
    return (w > pe) ? pe : w;
  endfunction

endpackage

// File: rtl/exp_ctl_settings.sv
module exp_ctl_settings #(
  parameter int LINE_W    = 16,
  parameter int CYC_W     = 4,
  parameter int IMG_LINES = 1092,
  parameter int PULSE_END = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [LINE_W-1:0] exp_lines,
  input  logic              shutter_en,
  input  logic [CYC_W-1:0]  sub_width,
  output logic [LINE_W-1:0] len_q,
  output logic [LINE_W-1:0] sline_q,
  output logic              use_q,
  output logic [CYC_W-1:0]  width_q
);
  import exp_ctl_pkg::*;

  int unsigned n_eff;
  always_comb n_eff = clamp_lines(32'(exp_lines));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= LINE_W'(IMG_LINES);
      sline_q <= '0;
      use_q   <= 1'b0;
      width_q <= CYC_W'(1);
    end else if (frame_tick) begin
      len_q   <= LINE_W'(frame_len(n_eff, IMG_LINES));
      sline_q <= LINE_W'(sub_line(n_eff, IMG_LINES));
      use_q   <= shutter_used(shutter_en, n_eff, IMG_LINES);
      width_q <= CYC_W'(clamp_width(32'(sub_width), PULSE_END));
    end
  end
endmodule

// File: rtl/exp_ctl_track.sv
module exp_ctl_track #(
  parameter int LINE_W    = 16,
  parameter int CYC_W     = 4,
  parameter int PULSE_END = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              line_tick,
  output logic              active_q,
  output logic [LINE_W-1:0] line_idx,
  output logic [CYC_W-1:0]  cyc_q
);
  localparam logic [CYC_W-1:0]  CYC_MAX  = CYC_W'(PULSE_END);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      line_idx <= '0;
      cyc_q    <= CYC_MAX;
    end else if (frame_tick) begin
      active_q <= 1'b1;
      line_idx <= '0;
      cyc_q    <= '0;
    end else if (line_tick) begin
      line_idx <= (line_idx == LINE_MAX) ? line_idx : line_idx + 1'b1;
      cyc_q    <= '0;
    end else if (cyc_q != CYC_MAX) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/exp_ctl_pulse.sv
module exp_ctl_pulse #(
  parameter int LINE_W    = 16,
  parameter int CYC_W     = 4,
  parameter int IMG_LINES = 1092,
  parameter int PULSE_END = 8,
  parameter int XFER_CYC  = 4
) (
  input  logic              active_q,
  input  logic [LINE_W-1:0] line_idx,
  input  logic [CYC_W-1:0]  cyc_q,
  input  logic              use_q,
  input  logic [LINE_W-1:0] sline_q,
  input  logic [CYC_W-1:0]  width_q,
  output logic              xfer_win,
  output logic              sub_win,
  output logic              xfer_req,
  output logic              sub_pulse,
  output logic              img_valid
);
  localparam logic [CYC_W-1:0]  END_C   = CYC_W'(PULSE_END);
  localparam logic [CYC_W-1:0]  XSTART  = CYC_W'(PULSE_END - XFER_CYC);
  localparam logic [LINE_W-1:0] IMG_C   = LINE_W'(IMG_LINES);

  logic [CYC_W-1:0] sstart;

  always_comb begin
    sstart    = END_C - width_q;
    xfer_win  = (cyc_q >= XSTART) && (cyc_q < END_C);
    sub_win   = (cyc_q >= sstart) && (cyc_q < END_C);
    xfer_req  = active_q && (line_idx == '0) && xfer_win;
    sub_pulse = active_q && use_q && (line_idx == sline_q) && sub_win;
    img_valid = active_q && (line_idx < IMG_C);
  end
endmodule

// File: rtl/exposure_ctl.sv
module exposure_ctl #(
  parameter int LINE_W    = 16,
  parameter int IMG_LINES = 1092,
  parameter int PULSE_END = 8,
  parameter int XFER_CYC  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_tick,
  input  logic                           line_tick,
  input  logic [LINE_W-1:0]              exp_lines,
  input  logic                           shutter_en,
  input  logic [$clog2(PULSE_END+1)-1:0] sub_width,
  output logic                           xfer_req,
  output logic                           sub_pulse,
  output logic [LINE_W-1:0]              frame_lines,
  output logic                           img_valid
);
  localparam int CYC_W = $clog2(PULSE_END + 1);

  logic [LINE_W-1:0] len_q, sline_q, line_idx;
  logic              use_q, active_q, xfer_win, sub_win;
  logic [CYC_W-1:0]  width_q, cyc_q;

  exp_ctl_settings #(.LINE_W(LINE_W), .CYC_W(CYC_W), .IMG_LINES(IMG_LINES),
                     .PULSE_END(PULSE_END)) u_set (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .exp_lines(exp_lines),
    .shutter_en(shutter_en), .sub_width(sub_width), .len_q(len_q),
    .sline_q(sline_q), .use_q(use_q), .width_q(width_q));

  exp_ctl_track #(.LINE_W(LINE_W), .CYC_W(CYC_W), .PULSE_END(PULSE_END)) u_trk (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .line_tick(line_tick),
    .active_q(active_q), .line_idx(line_idx), .cyc_q(cyc_q));

  exp_ctl_pulse #(.LINE_W(LINE_W), .CYC_W(CYC_W), .IMG_LINES(IMG_LINES),
                  .PULSE_END(PULSE_END), .XFER_CYC(XFER_CYC)) u_pls (
    .active_q(active_q), .line_idx(line_idx), .cyc_q(cyc_q), .use_q(use_q),
    .sline_q(sline_q), .width_q(width_q), .xfer_win(xfer_win), .sub_win(sub_win),
    .xfer_req(xfer_req), .sub_pulse(sub_pulse), .img_valid(img_valid));

  assign frame_lines = len_q;
endmodule

// File: rtl/exposure_ctl_chk.sv
module exposure_ctl_chk #(
  parameter int LINE_W    = 16,
  parameter int IMG_LINES = 1092,
  parameter int XFER_CYC  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              xfer_req,
  input logic              sub_pulse,
  input logic              img_valid,
  input logic [LINE_W-1:0] frame_lines
);
  logic [15:0] xcnt;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xcnt <= '0;
      seen <= 1'b0;
    end else begin
      xcnt <= xfer_req ? xcnt + 1'b1 : '0;
      seen <= seen | frame_tick;
    end
  end

  p_xfer_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_req) |-> (xcnt == 16'(XFER_CYC)));

  p_len_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lines >= LINE_W'(IMG_LINES));

  p_valid_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(img_valid) |-> $past(frame_tick));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(frame_lines));

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_req && sub_pulse));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (!xfer_req && !sub_pulse && !img_valid));
endmodule

bind exposure_ctl exposure_ctl_chk #(.LINE_W(LINE_W), .IMG_LINES(IMG_LINES),
                                     .XFER_CYC(XFER_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .xfer_req(xfer_req),
  .sub_pulse(sub_pulse), .img_valid(img_valid), .frame_lines(frame_lines));

// File: tb/tb_exposure_ctl.sv
module tb_exposure_ctl;
  localparam int LINE_W   = 8;
  localparam int IMG      = 16;
  localparam int PE       = 8;
  localparam int XC       = 4;
  localparam int CW       = $clog2(PE + 1);
  localparam int LINE_LEN = 12;

  typedef struct packed { logic [1:0] kind; int unsigned cyc; } ev_t;

  logic clk = 0, rst_n = 0, frame_tick = 0, line_tick = 0, shutter_en = 0;
  logic [LINE_W-1:0] exp_lines = '0;
  logic [CW-1:0]     sub_width = '0;
  logic xfer_req, sub_pulse, img_valid;
  logic [LINE_W-1:0] frame_lines;

  int checks = 0, errors = 0;
  int unsigned cyc_cnt = 0;
  bit done = 0;
  ev_t exp_q[$];
  int  gap_exp = 0;
  bit  gap_armed = 0;

  exposure_ctl #(.LINE_W(LINE_W), .IMG_LINES(IMG), .PULSE_END(PE), .XFER_CYC(XC)) dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .line_tick(line_tick),
    .exp_lines(exp_lines), .shutter_en(shutter_en), .sub_width(sub_width),
    .xfer_req(xfer_req), .sub_pulse(sub_pulse), .frame_lines(frame_lines),
    .img_valid(img_valid));

  always #4 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic check(bit ok, string req, int act, int expv, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic string kind_req(logic [1:0] k);
    return (k < 2) ? "R2" : "R3,R4";
  endfunction

  // Monitor: observe pulse edges at the falling clock edge and pop expectations.
  logic pv_x = 0, pv_s = 0;
  int unsigned t_sf = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        logic now, prv;
        logic [1:0] kd;
        now = (k == 0) ? xfer_req : sub_pulse;
        prv = (k == 0) ? pv_x : pv_s;
        if (now != prv) begin
          kd = 2'(k * 2 + (now ? 0 : 1));
          if (exp_q.size() == 0) begin
            check(0, kind_req(kd), int'(cyc_cnt), -1, "unexpected pulse edge");
          end else begin
            ev_t e;
            e = exp_q.pop_front();
            check(e.kind == kd && e.cyc == cyc_cnt, kind_req(e.kind),
                  int'(cyc_cnt), int'(e.cyc), $sformatf("edge kind %0d vs %0d", kd, e.kind));
          end
          if (kd == 2'd3) t_sf = cyc_cnt;
          if (kd == 2'd1 && gap_armed) begin
            // R3: integration window is exactly N lines
            check(int'(cyc_cnt - t_sf) == gap_exp, "R3", int'(cyc_cnt - t_sf), gap_exp,
                  "integration gap");
            gap_armed = 0;
          end
        end
      end
      pv_x <= xfer_req;
      pv_s <= sub_pulse;
    end
  end

  // Driver: play the sequencer for one frame and push expected pulse edges.
  task automatic do_frame(int n, bit en, int w);
    int ne, len, sl, wc;
    bit used;
    ne   = (n == 0) ? 1 : n;                     // R4
    len  = (ne > IMG) ? ne : IMG;                // R6
    used = en && (ne < IMG);                     // R3, R5
    sl   = IMG - ne;
    wc   = (w == 0) ? 1 : ((w > PE) ? PE : w);   // R4
    for (int k = 0; k < len; k++) begin
      line_tick = 1;
      if (k == 0) begin
        frame_tick = 1;
        exp_lines  = LINE_W'(n);
        shutter_en = en;
        sub_width  = CW'(w);
        exp_q.push_back('{kind: 2'd0, cyc: cyc_cnt + 1 + PE - XC});
        exp_q.push_back('{kind: 2'd1, cyc: cyc_cnt + 1 + PE});
      end
      if (used && k == sl) begin
        exp_q.push_back('{kind: 2'd2, cyc: cyc_cnt + 1 + PE - wc});
        exp_q.push_back('{kind: 2'd3, cyc: cyc_cnt + 1 + PE});
        gap_exp   = ne * LINE_LEN;
        gap_armed = 1;
      end
      @(negedge clk);
      line_tick  = 0;
      frame_tick = 0;
      if (k == 0) begin
        // R8: values changed right after the marker must be ignored
        exp_lines  = 8'd200;
        shutter_en = ~en;
        sub_width  = CW'(5);
      end
      repeat (2) @(negedge clk);
      check(img_valid == (k < IMG), "R7", int'(img_valid), int'(k < IMG),
            $sformatf("img_valid line %0d", k));
      if (k == 0)
        check(int'(frame_lines) == len, "R6", int'(frame_lines), len, "frame_lines");
      if (k == len - 1)
        check(int'(frame_lines) == len, "R8", int'(frame_lines), len, "frame_lines held");
      repeat (LINE_LEN - 3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(xfer_req == 0 && sub_pulse == 0, "R1", int'(xfer_req | sub_pulse), 0, "pulses in reset");
    check(img_valid == 0, "R1", int'(img_valid), 0, "img_valid in reset");
    check(int'(frame_lines) == IMG, "R1", int'(frame_lines), IMG, "frame_lines in reset");
    rst_n = 1;
    // R10: line markers before any frame marker do nothing
    shutter_en = 1; exp_lines = 8'd4; sub_width = CW'(3);
    for (int k = 0; k < 3; k++) begin
      line_tick = 1;
      @(negedge clk);
      line_tick = 0;
      repeat (LINE_LEN - 1) @(negedge clk);
      check(xfer_req == 0 && sub_pulse == 0 && img_valid == 0, "R10",
            int'({xfer_req, sub_pulse, img_valid}), 0, "idle before frame");
    end
    do_frame(4, 1, 3);     // short exposure, R3
    do_frame(0, 1, 0);     // zero clamps, R4
    do_frame(10, 1, 15);   // width clamp to PE, R4
    do_frame(10, 0, 3);    // shutter off, R5
    do_frame(32, 1, 3);    // doubled exposure padded, R6 R7
    do_frame(16, 1, 3);    // exactly one frame, R5
    do_frame(15, 1, 2);    // sub in line 1, R9 spacing
    do_frame(4, 0, 1);     // closes the previous integration
    repeat (4 * LINE_LEN) @(negedge clk);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0, "missing pulse edges");
    check(gap_armed == 0, "R3", int'(gap_armed), 0, "integration gap unchecked");
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule